// File: doc/BRIEF.md
# Register-Stack Arithmetic Unit

This block is an operand engine with no register numbers. Its operands sit in a small hardware stack. A load command pushes a value, taken either from the immediate field or from the memory read port, onto a new top entry. A binary command consumes the two uppermost entries and leaves one result in their place. A store command drives the top entry onto the store-data output and can optionally discard it.

Two further command forms leave the stack depth unchanged. They combine the top entry with a second operand and overwrite the top entry with the result. The second operand is either the entry a chosen number of places below the top, or a value taken from the immediate field or the memory port. A compare command consumes the two uppermost entries, writes no result, and updates the less-than and equal flags.

The arithmetic is integer add and subtract, and compares are signed. Every command takes one clock cycle. A command is offered with `cmd_valid`, and `done` answers it on the next cycle. Pushing onto a full stack, or asking for more entries than are present, raises a sticky fault. Such a command changes nothing else.

The fault indication is a two-state machine:
- `FS_CLEAN` moves to `FS_FAULTED` on any illegal stack access (transition "fault_seen").
- `FS_CLEAN` stays where it is on any legal command or on an idle cycle ("stay_clean").
- `FS_FAULTED` stays where it is until reset ("hold_fault").

Top module: `stack_alu_unit`

## Requirements
- R1: `cmd_op` 3'b000 pushes `imm_data` and 3'b001 pushes `mem_rdata`. The pushed value becomes the new top entry.
- R2: `cmd_op` 3'b011 replaces the two uppermost entries with one result. The result is next-below plus top when `cmd_sub`=0, and next-below minus top when `cmd_sub`=1.
- R3: `cmd_op` 3'b010 raises `store_valid` for one cycle, with `store_data` equal to the top entry, on the cycle after the command. With `cmd_pop`=1 it also removes the top entry. No other command raises `store_valid`.
- R4: `cmd_op` 3'b101 overwrites the top entry with top plus, or top minus (`cmd_sub`), the entry `cmd_idx` places below the top. `cmd_idx`=0 names the top entry itself.
- R5: `cmd_op` 3'b110 overwrites the top entry with top plus, or top minus (`cmd_sub`), the second operand. That operand is `imm_data` when `cmd_src`=0 and `mem_rdata` when `cmd_src`=1.
- R6: `cmd_op` 3'b100 removes the two uppermost entries. It sets `flag_lt` when next-below is less than top (signed) and sets `flag_eq` when the two are equal. No other command changes the flags.
- R7: A command that needs more entries than the stack holds sets `stack_fault` and leaves the stack, the flags and `store_valid` unchanged. `stack_fault` stays set until reset, and later commands still execute.
- R8: A push onto a stack holding 8 entries sets `stack_fault` and leaves the 8 entries unchanged.
- R9: Each accepted command pulses `done` for exactly one cycle, on the following cycle. `cmd_op` 3'b111 has no effect other than `done`.
- R10: After 8 pushes, removals return the values in reverse order. This holds repeatedly as the top pointer wraps around the storage.
- R11: After reset the stack is empty, and `done`, `store_valid`, `flag_lt`, `flag_eq` and `stack_fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_sub | input | 1 | 1 selects subtract, 0 selects add |
| cmd_pop | input | 1 | Store also removes the top entry |
| cmd_src | input | 1 | Operand source for 3'b110: 0 immediate, 1 memory |
| cmd_idx | input | PTR_W | Depth below the top for 3'b101 |
| imm_data | input | DATA_W | Immediate operand |
| mem_rdata | input | DATA_W | Memory read operand |
| done | output | 1 | Command completed last cycle |
| store_valid | output | 1 | Store data is valid |
| store_data | output | DATA_W | Value stored from the top entry |
| flag_lt | output | 1 | Last compare: next-below less than top |
| flag_eq | output | 1 | Last compare: operands equal |
| stack_fault | output | 1 | Sticky illegal stack access |

## Verification
A corrupted top pointer or valid tag shows up on `store_data` at the very next store. It also shows as a fault raised where none is due, or missing where one is due, on the cycle after the offending command. Wrong operand selection in the fold, depth-indexed or source-selected forms shows up as a wrong value on the first store after that command. Because the bench peeks at the top after almost every step, a bad entry is normally caught within one or two commands. Failures that only appear across a pointer wrap are exposed by draining full stacks in reverse order, which reads every slot.

// File: rtl/sau_pkg.sv
package sau_pkg;

    typedef enum logic [2:0] {
        OP_PUSH_IMM = 3'd0,
        OP_PUSH_MEM = 3'd1,
        OP_STORE    = 3'd2,
        OP_FOLD     = 3'd3,
        OP_CMP      = 3'd4,
        OP_REG      = 3'd5,
        OP_SRC      = 3'd6,
        OP_RSVD     = 3'd7
    } sau_op_e;

    typedef enum logic [2:0] {
        SA_NONE,
        SA_PUSH,
        SA_POP1,
        SA_POP2,
        SA_FOLD,
        SA_REPL
    } stk_act_e;

    typedef enum logic {
        FS_CLEAN,
        FS_FAULTED
    } fault_st_e;

endpackage

// File: rtl/sau_stack_file.sv
module sau_stack_file
    import sau_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_act_e          act,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  sel_idx,
    output logic [DATA_W-1:0] tos,
    output logic [DATA_W-1:0] nos,
    output logic [DATA_W-1:0] sel_data,
    output logic              has_tos,
    output logic              has_nos,
    output logic              has_sel,
    output logic              full
);

    logic [PTR_W-1:0]  tp_q;
    logic [PTR_W-1:0]  slot_up;
    logic [PTR_W-1:0]  slot_dn;
    logic [PTR_W-1:0]  slot_sel;
    logic [DATA_W-1:0] ent_w [DEPTH];
    logic [DEPTH-1:0]  vld_w;
    logic [DEPTH-1:0]  set_vec;
    logic [DEPTH-1:0]  clr_vec;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_slot;

    assign slot_up  = tp_q + PTR_W'(1);
    assign slot_dn  = tp_q - PTR_W'(1);
    assign slot_sel = tp_q - sel_idx;

    assign tos      = ent_w[tp_q];
    assign nos      = ent_w[slot_dn];
    assign sel_data = ent_w[slot_sel];
    assign has_tos  = vld_w[tp_q];
    assign has_nos  = vld_w[slot_dn];
    assign has_sel  = vld_w[slot_sel];
    assign full     = vld_w[slot_up];

    // Which slot is written and which valid tags change for each action.
    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        wr_en   = 1'b0;
        wr_slot = tp_q;
        case (act)
            SA_PUSH: begin
                wr_en            = 1'b1;
                wr_slot          = slot_up;
                set_vec[slot_up] = 1'b1;
            end
            SA_POP1: clr_vec[tp_q] = 1'b1;
            SA_POP2: begin
                clr_vec[tp_q]    = 1'b1;
                clr_vec[slot_dn] = 1'b1;
            end
            SA_FOLD: begin
                wr_en         = 1'b1;
                wr_slot       = slot_dn;
                clr_vec[tp_q] = 1'b1;
            end
            SA_REPL: wr_en = 1'b1;
            default: ;
        endcase
    end

    // Top pointer, wrapping modulo DEPTH.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tp_q <= '0;
        end else begin
            case (act)
                SA_PUSH: tp_q <= slot_up;
                SA_POP1: tp_q <= slot_dn;
                SA_POP2: tp_q <= tp_q - PTR_W'(2);
                SA_FOLD: tp_q <= slot_dn;
                default: ;
            endcase
        end
    end

    // One storage slot with its valid tag per stack entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DATA_W-1:0] ent_q;
        logic              vld_q;

        always_ff @(posedge clk) begin
            if (wr_en && (wr_slot == PTR_W'(g))) begin
                ent_q <= wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
            end else if (set_vec[g]) begin
                vld_q <= 1'b1;
            end else if (clr_vec[g]) begin
                vld_q <= 1'b0;
            end
        end

        assign ent_w[g] = ent_q;
        assign vld_w[g] = vld_q;
    end

endmodule

// File: rtl/sau_alu.sv
module sau_alu #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] res,
    output logic              lt,
    output logic              eq
);

    assign res = sub ? (a - b) : (a + b);
    assign lt  = $signed(a) < $signed(b);
    assign eq  = (a == b);

endmodule

// File: rtl/sau_seq.sv
module sau_seq
    import sau_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              cmd_sub,
    input  logic              cmd_pop,
    input  logic              cmd_src,
    input  logic [PTR_W-1:0]  cmd_idx,
    input  logic [DATA_W-1:0] imm_data,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] tos,
    input  logic [DATA_W-1:0] nos,
    input  logic [DATA_W-1:0] sel_data,
    input  logic              has_tos,
    input  logic              has_nos,
    input  logic              has_sel,
    input  logic              full,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              alu_lt,
    input  logic              alu_eq,
    output stk_act_e          act,
    output logic [DATA_W-1:0] wdata,
    output logic [PTR_W-1:0]  sel_idx,
    output logic [DATA_W-1:0] alu_a,
    output logic [DATA_W-1:0] alu_b,
    output logic              alu_sub,
    output logic              done,
    output logic              store_valid,
    output logic [DATA_W-1:0] store_data,
    output logic              flag_lt,
    output logic              flag_eq,
    output logic              stack_fault
);

    fault_st_e         state_q, state_d;
    sau_op_e           op;
    stk_act_e          plan_act;
    logic              illegal;
    logic              fault_ev;
    logic              is_store;
    logic              is_cmp;
    logic              done_q;
    logic              st_vld_q;
    logic [DATA_W-1:0] st_data_q;
    logic              lt_q, eq_q;

    assign op      = sau_op_e'(cmd_op);
    assign sel_idx = cmd_idx;
    assign alu_sub = cmd_sub;

    // Decode: operands, planned stack action and legality of the command.
    always_comb begin
        plan_act = SA_NONE;
        illegal  = 1'b0;
        is_store = 1'b0;
        is_cmp   = 1'b0;
        alu_a    = tos;
        alu_b    = nos;
        wdata    = alu_res;
        unique case (op)
            OP_PUSH_IMM: begin
                wdata    = imm_data;
                illegal  = full;
                plan_act = SA_PUSH;
            end
            OP_PUSH_MEM: begin
                wdata    = mem_rdata;
                illegal  = full;
                plan_act = SA_PUSH;
            end
            OP_STORE: begin
                illegal  = !has_tos;
                is_store = 1'b1;
                plan_act = cmd_pop ? SA_POP1 : SA_NONE;
            end
            OP_FOLD: begin
                alu_a    = nos;
                alu_b    = tos;
                illegal  = !has_nos;
                plan_act = SA_FOLD;
            end
            OP_CMP: begin
                alu_a    = nos;
                alu_b    = tos;
                illegal  = !has_nos;
                is_cmp   = 1'b1;
                plan_act = SA_POP2;
            end
            OP_REG: begin
                alu_b    = sel_data;
                illegal  = !has_sel;
                plan_act = SA_REPL;
            end
            OP_SRC: begin
                alu_b    = cmd_src ? mem_rdata : imm_data;
                illegal  = !has_tos;
                plan_act = SA_REPL;
            end
            OP_RSVD: plan_act = SA_NONE;
        endcase
    end

    assign fault_ev = cmd_valid && illegal;
    assign act      = (cmd_valid && !illegal) ? plan_act : SA_NONE;

    // Fault state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    // Fault state transitions: fault_seen, stay_clean, hold_fault.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_CLEAN:   if (fault_ev) state_d = FS_FAULTED;
            FS_FAULTED: state_d = FS_FAULTED;
        endcase
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            st_vld_q  <= 1'b0;
            st_data_q <= '0;
            lt_q      <= 1'b0;
            eq_q      <= 1'b0;
        end else begin
            done_q   <= cmd_valid;
            st_vld_q <= cmd_valid && is_store && !illegal;
            if (cmd_valid && is_store && !illegal) begin
                st_data_q <= tos;
            end
            if (cmd_valid && is_cmp && !illegal) begin
                lt_q <= alu_lt;
                eq_q <= alu_eq;
            end
        end
    end

    assign done        = done_q;
    assign store_valid = st_vld_q;
    assign store_data  = st_data_q;
    assign flag_lt     = lt_q;
    assign flag_eq     = eq_q;
    assign stack_fault = (state_q == FS_FAULTED);

endmodule

// File: rtl/stack_alu_unit.sv
module stack_alu_unit
    import sau_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              cmd_sub,
    input  logic              cmd_pop,
    input  logic              cmd_src,
    input  logic [PTR_W-1:0]  cmd_idx,
    input  logic [DATA_W-1:0] imm_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              store_valid,
    output logic [DATA_W-1:0] store_data,
    output logic              flag_lt,
    output logic              flag_eq,
    output logic              stack_fault
);

    stk_act_e          act;
    logic [DATA_W-1:0] wdata;
    logic [PTR_W-1:0]  sel_idx;
    logic [DATA_W-1:0] tos, nos, sel_data;
    logic              has_tos, has_nos, has_sel, full;
    logic [DATA_W-1:0] alu_a, alu_b, alu_res;
    logic              alu_sub, alu_lt, alu_eq;

    sau_stack_file #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .wdata    (wdata),
        .sel_idx  (sel_idx),
        .tos      (tos),
        .nos      (nos),
        .sel_data (sel_data),
        .has_tos  (has_tos),
        .has_nos  (has_nos),
        .has_sel  (has_sel),
        .full     (full)
    );

    sau_alu #(.DATA_W(DATA_W)) u_alu (
        .a   (alu_a),
        .b   (alu_b),
        .sub (alu_sub),
        .res (alu_res),
        .lt  (alu_lt),
        .eq  (alu_eq)
    );

    sau_seq #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_sub     (cmd_sub),
        .cmd_pop     (cmd_pop),
        .cmd_src     (cmd_src),
        .cmd_idx     (cmd_idx),
        .imm_data    (imm_data),
        .mem_rdata   (mem_rdata),
        .tos         (tos),
        .nos         (nos),
        .sel_data    (sel_data),
        .has_tos     (has_tos),
        .has_nos     (has_nos),
        .has_sel     (has_sel),
        .full        (full),
        .alu_res     (alu_res),
        .alu_lt      (alu_lt),
        .alu_eq      (alu_eq),
        .act         (act),
        .wdata       (wdata),
        .sel_idx     (sel_idx),
        .alu_a       (alu_a),
        .alu_b       (alu_b),
        .alu_sub     (alu_sub),
        .done        (done),
        .store_valid (store_valid),
        .store_data  (store_data),
        .flag_lt     (flag_lt),
        .flag_eq     (flag_eq),
        .stack_fault (stack_fault)
    );

endmodule

// File: rtl/sau_checker.sv
module sau_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       done,
    input logic       store_valid,
    input logic       flag_lt,
    input logic       flag_eq,
    input logic       stack_fault
);

    p_done_follows_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> done);

    p_no_done_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !done);

    p_store_only_from_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid || cmd_op != 3'd2) |=> !store_valid);

    p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stack_fault |=> stack_fault);

    p_fault_needs_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stack_fault && !cmd_valid) |=> !stack_fault);

    p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_op == 3'd4) |=> ($stable(flag_lt) && $stable(flag_eq)));

    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_lt && flag_eq));

endmodule

bind stack_alu_unit sau_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .done        (done),
    .store_valid (store_valid),
    .flag_lt     (flag_lt),
    .flag_eq     (flag_eq),
    .stack_fault (stack_fault)
);

// File: tb/stack_alu_unit_tb.sv
module stack_alu_unit_tb;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic          cmd_sub = 1'b0;
    logic          cmd_pop = 1'b0;
    logic          cmd_src = 1'b0;
    logic [2:0]    cmd_idx = '0;
    logic [DW-1:0] imm_data = '0;
    logic [DW-1:0] mem_rdata = '0;
    logic          done, store_valid, flag_lt, flag_eq, stack_fault;
    logic [DW-1:0] store_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    stack_alu_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_sub(cmd_sub), .cmd_pop(cmd_pop), .cmd_src(cmd_src), .cmd_idx(cmd_idx),
        .imm_data(imm_data), .mem_rdata(mem_rdata), .done(done),
        .store_valid(store_valid), .store_data(store_data), .flag_lt(flag_lt),
        .flag_eq(flag_eq), .stack_fault(stack_fault)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one command for one cycle; on return the outputs reflect it.
    task automatic issue(input logic [2:0] op, input logic [DW-1:0] imm, input logic [DW-1:0] mem,
                         input logic sub, input logic pop, input logic src, input logic [2:0] idx);
        @(negedge clk);
        cmd_op = op; imm_data = imm; mem_rdata = mem;
        cmd_sub = sub; cmd_pop = pop; cmd_src = src; cmd_idx = idx;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic push(input logic [DW-1:0] v);
        issue(3'd0, v, 16'h0, 1'b0, 1'b0, 1'b0, 3'd0);
    endtask

    task automatic store_chk(input logic pop, input logic [DW-1:0] exp, input string tag);
        issue(3'd2, 16'h0, 16'h0, 1'b0, pop, 1'b0, 3'd0);
        check({tag, " store_valid"}, 32'(store_valid), 32'd1);
        check({tag, " store_data"}, 32'(store_data), 32'(exp));
    endtask

    task automatic do_reset;
        cmd_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        do_reset();
        check("R11 done", 32'(done), 32'd0);
        check("R11 store_valid", 32'(store_valid), 32'd0);
        check("R11 flag_lt", 32'(flag_lt), 32'd0);
        check("R11 flag_eq", 32'(flag_eq), 32'd0);
        check("R11 stack_fault", 32'(stack_fault), 32'd0);
    endtask

    task automatic t_push;
        push(16'h0005);
        check("R9 done after push", 32'(done), 32'd1);
        check("R3 no store on push", 32'(store_valid), 32'd0);
        issue(3'd1, 16'hAAAA, 16'h0009, 1'b0, 1'b0, 1'b0, 3'd0);
        store_chk(1'b0, 16'h0009, "R1 push mem");
        store_chk(1'b1, 16'h0009, "R1 pop mem");
        store_chk(1'b1, 16'h0005, "R1 pop imm");
        check("R11 no fault yet", 32'(stack_fault), 32'd0);
    endtask

    task automatic t_fold;
        push(16'd20);
        push(16'd6);
        issue(3'd3, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 3'd0);
        store_chk(1'b0, 16'd26, "R2 fold add");
        push(16'd4);
        issue(3'd3, 16'h0, 16'h0, 1'b1, 1'b0, 1'b0, 3'd0);
        store_chk(1'b1, 16'd22, "R2 fold sub");
    endtask

    task automatic t_store;
        push(16'd1);
        push(16'd2);
        store_chk(1'b1, 16'd2, "R3 store pop");
        store_chk(1'b0, 16'd1, "R3 store keep");
        store_chk(1'b1, 16'd1, "R3 store keep then pop");
        @(negedge clk);
        check("R3 store_valid one cycle", 32'(store_valid), 32'd0);
    endtask

    task automatic t_reg;
        push(16'd10);
        push(16'd20);
        push(16'd30);
        issue(3'd5, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 3'd2);
        store_chk(1'b0, 16'd40, "R4 add idx2");
        issue(3'd5, 16'h0, 16'h0, 1'b1, 1'b0, 1'b0, 3'd1);
        store_chk(1'b0, 16'd20, "R4 sub idx1");
        issue(3'd5, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 3'd0);
        store_chk(1'b1, 16'd40, "R4 add idx0");
        store_chk(1'b1, 16'd20, "R4 below untouched");
        store_chk(1'b1, 16'd10, "R4 bottom untouched");
    endtask

    task automatic t_src;
        push(16'd100);
        issue(3'd6, 16'd23, 16'd500, 1'b0, 1'b0, 1'b0, 3'd0);
        store_chk(1'b0, 16'd123, "R5 add imm");
        issue(3'd6, 16'd77, 16'd3, 1'b1, 1'b0, 1'b1, 3'd0);
        store_chk(1'b1, 16'd120, "R5 sub mem");
    endtask

    task automatic t_cmp;
        push(16'h0055);
        push(16'd3);
        push(16'd7);
        issue(3'd4, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 3'd0);
        check("R6 lt 3<7", 32'(flag_lt), 32'd1);
        check("R6 eq 3<7", 32'(flag_eq), 32'd0);
        store_chk(1'b0, 16'h0055, "R6 compare pops both");
        push(16'hFFFF);
        push(16'd1);
        issue(3'd4, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 3'd0);
        check("R6 signed -1<1", 32'(flag_lt), 32'd1);
        push(16'd2);
        push(16'hFFFE);
        issue(3'd4, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 3'd0);
        check("R6 signed 2<-2 false", 32'(flag_lt), 32'd0);
        push(16'd9);
        push(16'd9);
        issue(3'd4, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 3'd0);
        check("R6 eq 9==9", 32'(flag_eq), 32'd1);
        check("R6 lt 9==9", 32'(flag_lt), 32'd0);
        push(16'd8);
        issue(3'd3, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 3'd0);
        check("R6 flags hold eq", 32'(flag_eq), 32'd1);
        check("R6 flags hold lt", 32'(flag_lt), 32'd0);
        store_chk(1'b1, 16'h005D, "R6 fold after compare");
        check("R6 no fault", 32'(stack_fault), 32'd0);
    endtask

    task automatic t_under;
        do_reset();
        issue(3'd2, 16'h0, 16'h0, 1'b0, 1'b1, 1'b0, 3'd0);
        check("R7 store on empty no data", 32'(store_valid), 32'd0);
        check("R7 fault on empty store", 32'(stack_fault), 32'd1);
        push(16'd5);
        issue(3'd3, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 3'd0);
        issue(3'd4, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 3'd0);
        check("R7 flags lt untouched", 32'(flag_lt), 32'd0);
        check("R7 flags eq untouched", 32'(flag_eq), 32'd0);
        store_chk(1'b0, 16'd5, "R7 contents kept");
        issue(3'd5, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 3'd1);
        store_chk(1'b1, 16'd5, "R7 deep index refused");
        check("R7 sticky", 32'(stack_fault), 32'd1);
        do_reset();
        check("R11 fault cleared by reset", 32'(stack_fault), 32'd0);
    endtask

    task automatic t_over;
        do_reset();
        for (int i = 1; i <= 8; i++) push(16'(i));
        check("R8 eight fit", 32'(stack_fault), 32'd0);
        push(16'd99);
        check("R8 ninth push faults", 32'(stack_fault), 32'd1);
        for (int i = 8; i >= 1; i--) store_chk(1'b1, 16'(i), "R8 R10 drain");
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 8; i++) push(16'(16 * r + i + 16));
            for (int i = 7; i >= 0; i--) store_chk(1'b1, 16'(16 * r + i + 16), "R10 wrap");
        end
        for (int i = 0; i < 5; i++) push(16'(i + 200));
        for (int i = 4; i >= 0; i--) store_chk(1'b1, 16'(i + 200), "R10 partial wrap");
    endtask

    task automatic t_done;
        do_reset();
        push(16'd7);
        @(negedge clk);
        check("R9 done drops", 32'(done), 32'd0);
        issue(3'd7, 16'd1, 16'd1, 1'b1, 1'b1, 1'b1, 3'd0);
        check("R9 done on reserved", 32'(done), 32'd1);
        check("R9 reserved no store", 32'(store_valid), 32'd0);
        check("R9 reserved no fault", 32'(stack_fault), 32'd0);
        store_chk(1'b1, 16'd7, "R9 reserved leaves stack");
    endtask

    initial begin
        t_reset();
        t_push();
        t_fold();
        t_store();
        t_reg();
        t_src();
        t_cmp();
        t_under();
        t_over();
        t_done();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule